// File: doc/BRIEF.md
# Flash array integrity signature checker

This block is a self-test sequencer for an on-chip flash array. Software enables it with a password, picks blocks through a block-select vector and arms a start bit. The controller then walks every location of each selected block that is not locked. It issues one read per cycle on the array read port and folds each returned word into a 160-bit multiple-input signature register (MISR). Each folded word is the raw 128-bit data, the raw 16-bit ECC field and the post-ECC single- and double-error flags.

Before a run, software seeds the MISR through five 32-bit signature registers. At the end it reads the compressed result back from the same registers and compares it with a precomputed golden value. Two bits in the control register set how the run reads the array: one chooses plain ascending addressing or a bit-reversed order, and one gives the margin-read polarity that goes out with every read. Clearing start during a run aborts it, and the done flag confirms that the abort has finished.

Top module: `flash_sig_checker`

## Requirements
- R1: Each captured read updates the signature as `next = {sig[158:0], fb} ^ {14'b0, cap}`, where `fb = sig[159]^sig[158]^sig[141]^sig[140]` and `cap` packs data in bits 127:0, ECC in bits 143:128, the single-error flag in bit 144 and the double-error flag in bit 145.
- R2: Only blocks whose select bit is 1 and whose lock bit is 0 are read. Each such block gets exactly 2^OFF_W reads, and a block that is both selected and locked gets none.
- R3: Register addresses 3 to 7 hold signature words 0 to 4 (word k is bits 32k+31:32k). Software writes them to seed the MISR and reads them back. After a run ends, the value holds until it is written again.
- R4: Control is at address 0. Writing exactly 0xF9F99999 sets enable (bit 31), and that write changes nothing else. A start request made without enable is ignored. Writing 0 clears both enable and start.
- R5: Writing control with bit 31 and bit 1 both set, while enable is on and start is off, launches a run. Done (bit 0) reads 0 during the run and 1 after the last read.
- R6: Array address is {block, offset}. With control bit 2 set, offsets ascend. With it clear, the offset is the bit-reversed value of an ascending count.
- R7: Clearing start while a run is busy stops all reads at once, and done goes to 1.
- R8: Control bit 3 is driven on `arr_margin_o` during every read of a run.
- R9: While a run is busy, writes to block-select (address 1), lock (address 2) and the signature words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| arr_req_o | output | 1 | Array read strobe; the word is captured in that cycle |
| arr_addr_o | output | 5 | Array address {block, offset} |
| arr_margin_o | output | 1 | Margin-read polarity for the access |
| arr_data_i | input | 128 | Uncorrected data |
| arr_ecc_i | input | 16 | Uncorrected ECC field |
| arr_sec_i | input | 1 | Single-error flag after ECC evaluation |
| arr_ded_i | input | 1 | Double-error flag after ECC evaluation |

## Verification
The bench aims at the cases where one slip in the skip logic or the ordering still gives a plausible signature. These include a block that is selected and locked, locks on blocks that are not selected, all blocks locked (the signature must equal the seed), and the bit-reversed order against the sequential one. The array model returns words that depend on the address and on the margin polarity. So a design that reads a locked block, drops the reversal or drives a stale margin bit ends with a different signature or read count. Other tests try to start without the password, write the configuration and the seed during a run, and abort partway through. A design that leaks any of these reaches the array or changes the signature, or it never raises done.

// File: rtl/flash_sig_pkg.sv
package flash_sig_pkg;
  localparam int unsigned SIG_W     = 160;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SIG_WORDS = SIG_W / WORD_W;
  localparam int unsigned DATA_W    = 128;
  localparam int unsigned ECC_W     = 16;
  localparam int unsigned CAP_W     = DATA_W + ECC_W + 2;

  localparam logic [31:0] UT_PASSWORD = 32'hF9F99999;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SEL  = 3'd1;
  localparam logic [2:0] RA_LOCK = 3'd2;
  localparam logic [2:0] RA_SIG0 = 3'd3;

  localparam int CB_DONE   = 0;
  localparam int CB_START  = 1;
  localparam int CB_SEQ    = 2;
  localparam int CB_MARGIN = 3;
  localparam int CB_EN     = 31;

  function automatic logic [SIG_W-1:0] misr_next(input logic [SIG_W-1:0] s,
                                                 input logic [CAP_W-1:0] c);
    logic fb;
    fb = s[159] ^ s[158] ^ s[141] ^ s[140];
    return {s[SIG_W-2:0], fb} ^ {{(SIG_W-CAP_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/sig_misr.sv
module sig_misr
  import flash_sig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_we_i,
  input  logic [2:0]        seed_idx_i,
  input  logic [WORD_W-1:0] seed_data_i,
  input  logic              upd_i,
  input  logic [CAP_W-1:0]  cap_i,
  output logic [SIG_W-1:0]  sig_o
);
  logic [SIG_W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else if (upd_i) sig_q <= misr_next(sig_q, cap_i);
    else if (seed_we_i) sig_q[seed_idx_i*WORD_W +: WORD_W] <= seed_data_i;
  end

  assign sig_o = sig_q;

  // R3: signature holds when neither captured nor seeded
  p_sig_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !seed_we_i) |=> $stable(sig_q));
endmodule

// File: rtl/sig_walker.sv
module sig_walker #(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned OFF_W   = 3,
  localparam int unsigned BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int unsigned ADDR_W = BLK_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               abort_i,
  input  logic               seq_i,
  input  logic [NUM_BLK-1:0] active_i,
  output logic               busy_o,
  output logic               finish_o,
  output logic               req_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic             busy_q;
  logic [BLK_W-1:0] blk_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_rev;
  logic             blk_end, last_blk;

  for (genvar i = 0; i < OFF_W; i++) begin : g_rev
    assign off_rev[i] = off_q[OFF_W-1-i];
  end

  assign req_o    = busy_q && active_i[blk_q];
  assign blk_end  = !active_i[blk_q] || (off_q == {OFF_W{1'b1}});
  assign last_blk = (blk_q == BLK_W'(NUM_BLK-1));
  assign finish_o = busy_q && (abort_i || (blk_end && last_blk));
  assign busy_o   = busy_q;
  assign addr_o   = {blk_q, seq_i ? off_q : off_rev};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      blk_q  <= '0;
      off_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      blk_q  <= '0;
      off_q  <= '0;
    end else if (busy_q) begin
      if (finish_o) begin
        busy_q <= 1'b0;
      end else if (blk_end) begin
        off_q <= '0;
        blk_q <= blk_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  // R2: a skipped block moves on with the offset back at zero
  p_skip_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !finish_o && !launch_i && !req_o) |=> (busy_q && off_q == '0));
endmodule

// File: rtl/flash_sig_checker.sv
module flash_sig_checker
  import flash_sig_pkg::*;
#(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned OFF_W   = 3,
  localparam int unsigned BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int unsigned ADDR_W = BLK_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               arr_req_o,
  output logic [ADDR_W-1:0]  arr_addr_o,
  output logic               arr_margin_o,
  input  logic [DATA_W-1:0]  arr_data_i,
  input  logic [ECC_W-1:0]   arr_ecc_i,
  input  logic               arr_sec_i,
  input  logic               arr_ded_i
);
  logic               ut_en_q, start_q, seq_q, margin_q, done_q;
  logic [NUM_BLK-1:0] sel_q, lock_q;
  logic               busy, finish, req;
  logic               ctrl_wr, pw_hit, go_req, launch, abort;
  logic               is_sig;
  logic [2:0]         sig_idx;
  logic [SIG_W-1:0]   sig;

  assign ctrl_wr = reg_we_i && reg_addr_i == RA_CTRL;
  assign pw_hit  = reg_wdata_i == UT_PASSWORD;
  assign go_req  = ut_en_q && reg_wdata_i[CB_EN] && reg_wdata_i[CB_START];
  assign launch  = ctrl_wr && !pw_hit && go_req && !start_q && !busy;
  assign abort   = ctrl_wr && !pw_hit && !go_req && busy;
  assign is_sig  = reg_addr_i >= RA_SIG0;
  assign sig_idx = reg_addr_i - RA_SIG0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ut_en_q  <= 1'b0;
      start_q  <= 1'b0;
      seq_q    <= 1'b0;
      margin_q <= 1'b0;
      done_q   <= 1'b0;
      sel_q    <= '0;
      lock_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        if (pw_hit) begin
          ut_en_q <= 1'b1;
        end else begin
          ut_en_q <= ut_en_q && reg_wdata_i[CB_EN];
          start_q <= go_req;
          if (!busy) begin
            seq_q    <= reg_wdata_i[CB_SEQ];
            margin_q <= reg_wdata_i[CB_MARGIN];
          end
        end
      end
      if (launch) done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
      if (reg_we_i && !busy && reg_addr_i == RA_SEL)  sel_q  <= reg_wdata_i[NUM_BLK-1:0];
      if (reg_we_i && !busy && reg_addr_i == RA_LOCK) lock_q <= reg_wdata_i[NUM_BLK-1:0];
    end
  end

  sig_walker #(.NUM_BLK(NUM_BLK), .OFF_W(OFF_W)) u_walker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .abort_i  (abort),
    .seq_i    (seq_q),
    .active_i (sel_q & ~lock_q),
    .busy_o   (busy),
    .finish_o (finish),
    .req_o    (req),
    .addr_o   (arr_addr_o)
  );

  sig_misr u_misr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seed_we_i   (reg_we_i && is_sig && !busy),
    .seed_idx_i  (sig_idx),
    .seed_data_i (reg_wdata_i),
    .upd_i       (req && !abort),
    .cap_i       ({arr_ded_i, arr_sec_i, arr_ecc_i, arr_data_i}),
    .sig_o       (sig)
  );

  assign arr_req_o    = req;
  assign arr_margin_o = margin_q;

  always_comb begin
    reg_rdata_o = '0;
    if (is_sig) reg_rdata_o = sig[sig_idx*WORD_W +: WORD_W];
    else if (reg_addr_i == RA_SEL)  reg_rdata_o[NUM_BLK-1:0] = sel_q;
    else if (reg_addr_i == RA_LOCK) reg_rdata_o[NUM_BLK-1:0] = lock_q;
    else begin
      reg_rdata_o[CB_EN]     = ut_en_q;
      reg_rdata_o[CB_MARGIN] = margin_q;
      reg_rdata_o[CB_SEQ]    = seq_q;
      reg_rdata_o[CB_START]  = start_q;
      reg_rdata_o[CB_DONE]   = done_q;
    end
  end

  p_start_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ut_en_q);

  p_done_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q);

  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(sel_q) && $stable(lock_q)));
endmodule

// File: tb/tb_flash_sig_checker.sv
module tb_flash_sig_checker;
  localparam int NB = 4;
  localparam int OW = 3;
  localparam int AW = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         arr_req, arr_margin;
  logic [AW-1:0] arr_addr;
  logic [127:0] arr_data;
  logic [15:0]  arr_ecc;
  logic         arr_sec, arr_ded;

  int checks = 0, errors = 0;
  int req_cnt = 0, margin_bad = 0;
  logic exp_margin = 1'b0;

  always #5 clk = ~clk;

  flash_sig_checker #(.NUM_BLK(NB), .OFF_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .arr_req_o(arr_req),
    .arr_addr_o(arr_addr), .arr_margin_o(arr_margin), .arr_data_i(arr_data),
    .arr_ecc_i(arr_ecc), .arr_sec_i(arr_sec), .arr_ded_i(arr_ded)
  );

  function automatic logic [145:0] arr_word(input logic [AW-1:0] a, input logic m);
    logic [145:0] w;
    for (int i = 0; i < 4; i++)
      w[i*32 +: 32] = (32'(a) * 32'h9E3779B1) ^ (32'h01010101 * i) ^ {32{m}};
    w[143:128] = 16'(32'(a) * 37 + 5) ^ {16{m}};
    w[144] = a[1];
    w[145] = a[0] & a[2];
    return w;
  endfunction

  always_comb begin
    logic [145:0] w;
    w = arr_word(arr_addr, arr_margin);
    arr_data = w[127:0];
    arr_ecc  = w[143:128];
    arr_sec  = w[144];
    arr_ded  = w[145];
  end

  always @(negedge clk) if (arr_req) begin
    req_cnt++;
    if (arr_margin !== exp_margin) margin_bad++;
  end

  function automatic logic [159:0] step(input logic [159:0] s, input logic [145:0] c);
    logic f;
    f = s[159] ^ s[158] ^ s[141] ^ s[140];
    return {s[158:0], f} ^ {14'b0, c};
  endfunction

  function automatic logic [159:0] model(input logic [3:0] sel, input logic [3:0] lock,
                                         input logic seq, input logic m, input logic [31:0] seed);
    logic [159:0] s;
    for (int k = 0; k < 5; k++) s[k*32 +: 32] = seed ^ 32'(k);
    for (int b = 0; b < NB; b++)
      if (sel[b] && !lock[b])
        for (int o = 0; o < 8; o++) begin
          logic [2:0] off;
          off = 3'(o);
          if (!seq) off = {off[0], off[1], off[2]};
          s = step(s, arr_word({2'(b), off}, m));
        end
    return s;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_sig(output logic [159:0] s);
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      rd(3'(3 + k), d);
      s[k*32 +: 32] = d;
    end
  endtask

  task automatic seed_sig(input logic [31:0] seed);
    for (int k = 0; k < 5; k++) wr(3'(3 + k), seed ^ 32'(k));
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      rd(3'd0, d);
      if (d[0]) begin ok = 1'b1; break; end
    end
  endtask

  // sel[41:38] lock[37:34] seq[33] margin[32] seed[31:0]
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {4'hF, 4'h0, 1'b1, 1'b0, 32'h00000000},
    {4'hF, 4'h0, 1'b0, 1'b0, 32'h00000000},
    {4'h6, 4'h0, 1'b0, 1'b1, 32'h12345678},
    {4'h6, 4'h4, 1'b1, 1'b0, 32'hDEADBEEF},
    {4'h9, 4'h6, 1'b0, 1'b1, 32'h00000000},
    {4'hF, 4'hF, 1'b1, 1'b0, 32'hA5A5A5A5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [159:0] s, s2, e;
    bit ok;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    ok = !arr_req;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      if (d !== 32'h0) ok = 1'b0;
    end
    chk(ok, "R5 reset all registers zero", 160'(d), 160'h0);

    // R4 password, start without enable, clear by zero
    req_cnt = 0;
    wr(3'd0, 32'h80000002);
    repeat (10) @(negedge clk);
    rd(3'd0, d);
    chk(d == 32'h0 && req_cnt == 0, "R4 start ignored without enable", 160'(d), 160'h0);
    wr(3'd0, 32'hF9F99999);
    rd(3'd0, d);
    chk(d == 32'h80000000, "R4 password sets only enable", 160'(d), 160'h80000000);
    wr(3'd0, 32'h0);
    rd(3'd0, d);
    chk(d == 32'h0, "R4 zero write clears enable", 160'(d), 160'h0);

    // R3 seed readback
    seed_sig(32'hCAFE0000);
    rd_sig(s);
    e = model(4'h0, 4'h0, 1'b1, 1'b0, 32'hCAFE0000);
    chk(s == e, "R3 seed readback", s, e);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0] sel, lock;
      logic seq, m;
      logic [31:0] seed;
      {sel, lock, seq, m, seed} = VEC[v];
      wr(3'd0, 32'hF9F99999);
      wr(3'd1, 32'(sel));
      wr(3'd2, 32'(lock));
      seed_sig(seed);
      exp_margin = m;
      req_cnt = 0; margin_bad = 0;
      wr(3'd0, {1'b1, 27'b0, m, seq, 1'b1, 1'b0});
      wait_done(ok);
      chk(ok, "R5 done rises after run", 160'(ok), 160'h1);
      n = $countones(sel & ~lock) * 8;
      chk(req_cnt == n, "R2 read count over unlocked selected blocks", 160'(req_cnt), 160'(n));
      chk(margin_bad == 0, "R8 margin bit on every read", 160'(margin_bad), 160'h0);
      rd_sig(s);
      e = model(sel, lock, seq, m, seed);
      chk(s == e, seq ? "R1 R2 signature sequential" : "R1 R6 signature bit-reversed", s, e);
      repeat (5) @(negedge clk);
      rd_sig(s2);
      chk(s2 == s, "R3 signature held after done", s2, s);
      wr(3'd0, 32'h0);
    end

    // R9 writes during run ignored
    wr(3'd0, 32'hF9F99999);
    wr(3'd1, 32'hF);
    wr(3'd2, 32'h0);
    seed_sig(32'h0);
    exp_margin = 1'b0; req_cnt = 0; margin_bad = 0;
    wr(3'd0, 32'h80000006);
    wr(3'd1, 32'h1);
    wr(3'd2, 32'hF);
    wr(3'd3, 32'hFFFFFFFF);
    wait_done(ok);
    rd(3'd1, d);
    rd(3'd2, d2);
    chk(ok && d == 32'hF && d2 == 32'h0, "R9 select and lock frozen during run",
        {64'h0, d, d2}, {64'h0, 32'hF, 32'h0});
    rd_sig(s);
    e = model(4'hF, 4'h0, 1'b1, 1'b0, 32'h0);
    chk(s == e, "R9 seed write during run ignored", s, e);
    wr(3'd0, 32'h0);

    // R7 abort
    wr(3'd0, 32'hF9F99999);
    req_cnt = 0;
    wr(3'd0, 32'h80000002);
    wr(3'd0, 32'h80000000);
    rd(3'd0, d);
    chk(d[0] == 1'b1 && d[1] == 1'b0, "R7 abort raises done", 160'(d), 160'h80000001);
    n = req_cnt;
    repeat (10) @(negedge clk);
    chk(req_cnt == n && n < 32, "R7 no reads after abort", 160'(req_cnt), 160'(n));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule